// File: doc/BRIEF.md
# Memset Request Splitter

This block sits in front of a memory-side page engine. It accepts one fill request at a time, made of a start byte address, a byte count and a fill byte. It breaks the request into two kinds of work: whole-page set commands, which go to the page engine, and single-byte writes for everything that does not cover a whole aligned page.

The splitter walks the request from the low address upward. Bytes before the first page boundary are written one at a time. Every aligned page that lies fully inside the request then becomes one page command. Whatever is left after the last whole page is written bytewise again. Page commands use a valid/ready handshake, and byte writes use their own valid/ready write port. Both carry the request's fill byte. A one-cycle completion pulse marks the end of each request, including a request of zero length.

The page size is a parameter given as its base-two logarithm. The default is 4096 bytes. Address and length widths are also parameters.

Top module: `memset_splitter`

## Requirements
- R1: After reset `req_ready` is 1, and `pg_valid`, `wr_valid` and `done` are 0.
- R2: A request accepted with `req_len` = 0 produces no page command and no byte write. `done` is 1 in the cycle after the acceptance edge.
- R3: When the start address is not a multiple of the page size, the bytes up to the next page boundary (or up to the end of the request, if it comes first) are written one at a time before any page command.
- R4: A page command is offered only when the current address has its low PAGE_LG bits all zero and at least one page of bytes remains. For a request it issues exactly (len − head) / page-size commands, with integer division, where head is the byte count of R3.
- R5: Each accepted page command moves the current address forward by exactly one page size and lowers the remaining count by one page size. The next command or write therefore starts at the old address plus the page size.
- R6: Once fewer than a page of bytes remain, each accepted byte write covers the current address and steps it by one. Writes continue until the address reaches start + len. Across the whole request, the commands and writes cover every address from start to start + len − 1 exactly once, in ascending order.
- R7: While `pg_valid` (or `wr_valid`) is high and its ready is low, the valid stays high and the offered address does not change.
- R8: `pg_valid` and `wr_valid` are never high together. `req_ready` is low from request acceptance until the completion cycle.
- R9: `done` is a single-cycle pulse, raised once per request in the cycle after the final page command or byte write is accepted.
- R10: `pg_fill` and `wr_data` equal the `req_fill` byte of the request being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request offered |
| req_ready | output | 1 | Splitter idle; request accepted when both high |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_fill | input | 8 | Fill byte |
| pg_valid | output | 1 | Page set command offered |
| pg_ready | input | 1 | Page engine accepts command |
| pg_addr | output | ADDR_W | Page-aligned base address of the command |
| pg_fill | output | 8 | Fill byte for the page |
| wr_valid | output | 1 | Byte write offered |
| wr_ready | input | 1 | Write port accepts byte |
| wr_addr | output | ADDR_W | Byte address |
| wr_data | output | 8 | Byte value |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong current address or remaining count shows up at the very next accepted command or write. The bench then sees an address that breaks the ascending, gap-free walk, or a page command at an unaligned address. A bad choice between page and byte work shows up as a wrong count of page commands against byte writes by the end of the request. A remaining count that misses zero shows up as a missing, early or late `done`, compared with the cycle after the last accepted transfer. The bench sweeps every start offset across two pages and every length up to two and a half pages. It alternates full-rate and pseudo-random back-pressure on both output ports.

// File: rtl/msplit_pkg.sv
package msplit_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } split_st_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_BYTE = 2'd1,
        STEP_PAGE = 2'd2
    } step_e;

endpackage

// File: rtl/msplit_step_pick.sv
module msplit_step_pick
    import msplit_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 32,
    parameter int PAGE_LG = 12
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  cur_rem,
    output step_e             step_kind
);

    localparam logic [LEN_W-1:0] PAGE_LEN = {{(LEN_W-1){1'b0}}, 1'b1} << PAGE_LG;

    logic at_boundary;
    logic page_fits;

    always_comb begin
        at_boundary = (cur_addr[PAGE_LG-1:0] == '0);
        page_fits   = (cur_rem >= PAGE_LEN);
        if (cur_rem == '0) begin
            step_kind = STEP_NONE;
        end else if (at_boundary && page_fits) begin
            step_kind = STEP_PAGE;
        end else begin
            step_kind = STEP_BYTE;
        end
    end

endmodule

// File: rtl/msplit_sequencer.sv
module msplit_sequencer
    import msplit_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 32,
    parameter int PAGE_LG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        req_fill,
    output logic              req_ready,
    input  step_e             step_kind,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  cur_rem,
    output logic [7:0]        cur_fill,
    output logic              pg_valid,
    input  logic              pg_ready,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic              done
);

    localparam logic [LEN_W-1:0]  PAGE_LEN  = {{(LEN_W-1){1'b0}}, 1'b1} << PAGE_LG;
    localparam logic [ADDR_W-1:0] PAGE_STEP = {{(ADDR_W-1){1'b0}}, 1'b1} << PAGE_LG;
    localparam logic [LEN_W-1:0]  ONE_LEN   = {{(LEN_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] ONE_ADDR  = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        split_st_e         st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [7:0]        fill;
        logic              done;
    } seq_state_t;

    seq_state_t state_d, state_q;
    logic       fire_pg, fire_wr;
    logic [LEN_W-1:0] rem_after;

    always_comb begin
        state_d       = state_q;
        state_d.done  = 1'b0;
        pg_valid      = (state_q.st == ST_RUN) && (step_kind == STEP_PAGE);
        wr_valid      = (state_q.st == ST_RUN) && (step_kind == STEP_BYTE);
        fire_pg       = pg_valid && pg_ready;
        fire_wr       = wr_valid && wr_ready;
        rem_after     = state_q.rem;
        case (state_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d.addr = req_addr;
                    state_d.rem  = req_len;
                    state_d.fill = req_fill;
                    if (req_len == '0) begin
                        state_d.done = 1'b1;
                    end else begin
                        state_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (fire_pg) begin
                    rem_after     = state_q.rem - PAGE_LEN;
                    state_d.addr  = state_q.addr + PAGE_STEP;
                end else if (fire_wr) begin
                    rem_after     = state_q.rem - ONE_LEN;
                    state_d.addr  = state_q.addr + ONE_ADDR;
                end
                state_d.rem = rem_after;
                if ((fire_pg || fire_wr) && (rem_after == '0)) begin
                    state_d.st   = ST_IDLE;
                    state_d.done = 1'b1;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.st   <= ST_IDLE;
            state_q.addr <= '0;
            state_q.rem  <= '0;
            state_q.fill <= '0;
            state_q.done <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready = (state_q.st == ST_IDLE);
    assign cur_addr  = state_q.addr;
    assign cur_rem   = state_q.rem;
    assign cur_fill  = state_q.fill;
    assign done      = state_q.done;

    // R8
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pg_valid && wr_valid));

    // R4
    page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_valid |-> (cur_addr[PAGE_LG-1:0] == '0) && (cur_rem >= PAGE_LEN));

    // R7
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_valid && !pg_ready) |=> (pg_valid && $stable(cur_addr)));

    // R7
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(cur_addr)));

    // R2
    zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len == '0)) |=> (done && req_ready));

    // R9
    last_byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && (cur_rem == ONE_LEN)) |=> done);

    // R8
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_valid || wr_valid) |-> !req_ready);

endmodule

// File: rtl/memset_splitter.sv
module memset_splitter
    import msplit_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 32,
    parameter int PAGE_LG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        req_fill,
    output logic              pg_valid,
    input  logic              pg_ready,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [7:0]        pg_fill,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done
);

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_rem;
    logic [7:0]        cur_fill;
    step_e             step_kind;

    msplit_step_pick #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .PAGE_LG(PAGE_LG)
    ) u_pick (
        .cur_addr (cur_addr),
        .cur_rem  (cur_rem),
        .step_kind(step_kind)
    );

    msplit_sequencer #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .PAGE_LG(PAGE_LG)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_len  (req_len),
        .req_fill (req_fill),
        .req_ready(req_ready),
        .step_kind(step_kind),
        .cur_addr (cur_addr),
        .cur_rem  (cur_rem),
        .cur_fill (cur_fill),
        .pg_valid (pg_valid),
        .pg_ready (pg_ready),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .done     (done)
    );

    assign pg_addr = cur_addr;
    assign pg_fill = cur_fill;
    assign wr_addr = cur_addr;
    assign wr_data = cur_fill;

endmodule

// File: tb/memset_splitter_bench.sv
module memset_splitter_bench;

    localparam int AW = 8;
    localparam int LW = 8;
    localparam int PL = 4;
    localparam int PB = 1 << PL;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_ready;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic [7:0]    req_fill;
    logic          pg_valid, pg_ready, wr_valid, wr_ready, done;
    logic [AW-1:0] pg_addr, wr_addr;
    logic [7:0]    pg_fill, wr_data;

    memset_splitter #(.ADDR_W(AW), .LEN_W(LW), .PAGE_LG(PL)) u_memset_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_fill(req_fill),
        .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_addr(pg_addr), .pg_fill(pg_fill),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] lf = 16'hACE1;
    int rmode, ptr, left, n_pg, n_wr, n_done, t, last_hs, done_t;
    logic [7:0] fillv;
    logic hold_pg, hold_wr;
    logic [AW-1:0] hold_pa, hold_wa;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        req_valid = 1'b0;
        if (rmode == 0) begin
            pg_ready = 1'b1;
            wr_ready = 1'b1;
        end else begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pg_ready = lf[0] | lf[3];
            wr_ready = lf[1] | lf[6];
        end
        #1;
        t++;
        if (pg_valid && wr_valid) chk(1'b0, "R8", "both valids high", 1, 0);
        if (hold_pg) chk(pg_valid && (pg_addr == hold_pa), "R7", "page addr held", int'(pg_addr), int'(hold_pa));
        if (hold_wr) chk(wr_valid && (wr_addr == hold_wa), "R7", "byte addr held", int'(wr_addr), int'(hold_wa));
        hold_pg = pg_valid && !pg_ready;
        hold_pa = pg_addr;
        hold_wr = wr_valid && !wr_ready;
        hold_wa = wr_addr;
        if (n_done == 0 && !done) chk(!req_ready, "R8", "req_ready while busy", int'(req_ready), 0);
        if (done) begin
            n_done++;
            done_t = t;
            chk(left == 0, "R9", "bytes left at done", left, 0);
        end
        if (pg_valid && pg_ready) begin
            n_pg++;
            last_hs = t;
            chk((ptr % PB == 0) && (left >= PB), "R4", "page cmd legal at ptr", ptr, left);
            chk(int'(pg_addr) == ptr, "R5", "page addr", int'(pg_addr), ptr);
            chk(pg_fill == fillv, "R10", "page fill", int'(pg_fill), int'(fillv));
            ptr += PB;
            left -= PB;
        end
        if (wr_valid && wr_ready) begin
            n_wr++;
            last_hs = t;
            chk(!((ptr % PB == 0) && (left >= PB)), (n_pg == 0) ? "R3" : "R6",
                "byte write where page expected", ptr, left);
            chk(int'(wr_addr) == ptr, "R6", "byte addr", int'(wr_addr), ptr);
            chk(wr_data == fillv, "R10", "byte data", int'(wr_data), int'(fillv));
            ptr += 1;
            left -= 1;
        end
    endtask

    task automatic run_req(input int a, input int l, input int m);
        int head, pages, tail;
        rmode = m;
        ptr = a; left = l; n_pg = 0; n_wr = 0; n_done = 0;
        t = 0; last_hs = 0; done_t = 0;
        hold_pg = 1'b0; hold_wr = 1'b0;
        fillv = 8'((a * 7 + l * 13 + 1) & 8'hFF);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_len   = LW'(l);
        req_fill  = fillv;
        #1;
        chk(req_ready, "R8", "ready when idle", int'(req_ready), 1);
        while (n_done == 0 && t < 400) tick();
        if (n_done == 0) chk(1'b0, "R9", "watchdog no done", 0, 1);
        tick();
        tick();
        chk(n_done == 1, "R9", "done pulses", n_done, 1);
        head = (a % PB == 0) ? 0 : PB - (a % PB);
        if (head > l) head = l;
        pages = (l - head) / PB;
        tail = l - head - pages * PB;
        chk(n_pg == pages, "R4", "page command count", n_pg, pages);
        chk(n_wr == head + tail, "R6", "byte write count", n_wr, head + tail);
        chk(ptr == a + l, "R6", "end address", ptr, a + l);
        if (l == 0) begin
            chk(done_t == 1, "R2", "zero length done cycle", done_t, 1);
            chk(n_pg + n_wr == 0, "R2", "zero length transfers", n_pg + n_wr, 0);
        end else begin
            chk(done_t == last_hs + 1, "R9", "done after last transfer", done_t, last_hs + 1);
        end
    endtask

    initial begin
        #(4 * 195000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_len = '0; req_fill = '0;
        pg_ready = 1'b0; wr_ready = 1'b0;
        rmode = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
        chk(pg_valid == 1'b0, "R1", "reset pg_valid", int'(pg_valid), 0);
        chk(wr_valid == 1'b0, "R1", "reset wr_valid", int'(wr_valid), 0);
        chk(done == 1'b0, "R1", "reset done", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 2 * PB; a++) begin
            for (int l = 0; l <= 2 * PB + PB / 2; l++) begin
                run_req(a, l, (a + l) % 2);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule